// File: doc/BRIEF.md
# Externally Clocked Serial Slave with Double Buffering

This block is a full-duplex synchronous serial port that acts as a clock-input slave. An external device supplies the shift clock, and the port exchanges 8-bit frames on one output line and one input line. Both lines shift at the same time, least significant bit first. The shift clock idles high. On each falling edge the port drives the next outgoing bit. On each rising edge it samples the incoming bit. The shift clock and the serial input pass through a synchronizer into the system clock domain. The system clock must run at least four times faster than the shift clock.

On the host side the port has a byte write strobe for outgoing data and a byte read strobe for incoming data. The receive side always has two stages: a shift register and a readable holding register. A mode input selects the transmit side. With the mode input low, the transmit side has one buffer. With it high, it has two stages, a host holding register and a staging register, so that two bytes can wait. The port raises one-cycle transmit and receive interrupt pulses at fixed points of each frame. It also keeps sticky overrun and underrun flags, which a clear strobe resets.

Top module: `sclk_slave_port`

## Requirements
- R1: After reset, ser_out is 1, rd_valid is 0, ovr_flag and udr_flag are 0, and neither interrupt pulses.
- R2: A frame is 8 falling/rising shift-clock pairs. The outgoing byte's bit k is on ser_out from the k-th falling edge (counting from 0) until the next falling edge, so bit 0 goes first.
- R3: The 8 bits sampled on the 8 rising edges of a frame form the received byte, with the first bit at bit position 0. The host reads this byte from rd_data.
- R4: On the last rising edge of a frame, if the readable stage is free, the received byte moves into rd_data and rd_valid goes to 1. rx_irq pulses for exactly one system cycle at that moment.
- R5: tx_irq pulses for exactly one cycle on the last rising edge of every frame, in both transmit modes. Whenever rx_irq pulses, tx_irq pulses in the same cycle.
- R6: With dbuf_en = 0, a byte written before the first falling edge of a frame is sent in that frame. If no byte is waiting, the frame sends all ones and udr_flag is not set.
- R7: With dbuf_en = 1, two bytes written while idle are sent in write order in two consecutive frames. At the end of each frame the holding register's byte moves into the staging register.
- R8: With dbuf_en = 1, if the staging register is empty at the first falling edge of a frame, udr_flag is set and the frame sends all ones.
- R9: If rd_valid is still 1 (no read in that cycle) at the last rising edge of a frame, ovr_flag is set, rd_data keeps the unread byte, the new byte is dropped and rx_irq does not pulse.
- R10: A one-cycle rd_en pulse clears rd_valid. ovr_flag and udr_flag stay set until a one-cycle err_clr pulse clears them.
- R11: Every shift-clock edge takes effect on the registered outputs exactly three system clock cycles after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sck | input | 1 | External shift clock, idles high |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| dbuf_en | input | 1 | 1 selects two transmit stages, 0 selects one |
| wr_en | input | 1 | Write strobe for transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Read strobe, marks readable stage empty |
| rd_data | output | 8 | Readable receive stage |
| rd_valid | output | 1 | Readable stage holds an unread byte |
| err_clr | input | 1 | Clears both error flags |
| ovr_flag | output | 1 | Sticky receive overrun |
| udr_flag | output | 1 | Sticky transmit underrun |
| tx_irq | output | 1 | Transmit frame-complete pulse |
| rx_irq | output | 1 | Receive-stage-loaded pulse |

## Verification
A shift-clock edge passes through two synchronizer flops and one output register, so its result appears on the third system clock edge after it is applied. The bench drives the last rising edge of every frame and then checks both interrupts. The checks expect the interrupts low two cycles later and high, as the model predicts, three cycles later. The bench samples each outgoing bit just before it raises the shift clock, eight cycles after the falling edge. Host strobes act on the next clock edge, so the bench samples rd_valid and the flags on the following falling clock edge.

// File: rtl/sslv_pkg.sv
package sslv_pkg;
  typedef enum logic [1:0] {
    TXSRC_FILL,
    TXSRC_HOLD,
    TXSRC_STAGE
  } txsrc_e;
endpackage

// File: rtl/sslv_edge_sync.sv
module sslv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] sdi_q;
  logic              sck_last_q;

  // synchronizer chains; shift clock idles high so resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= '1;
      sdi_q      <= '0;
      sck_last_q <= 1'b1;
    end else begin
      sck_q      <= {sck_q[STAGES-2:0], sck_i};
      sdi_q      <= {sdi_q[STAGES-2:0], sdi_i};
      sck_last_q <= sck_q[STAGES-1];
    end
  end

  assign rise_o = sck_q[STAGES-1] & ~sck_last_q;
  assign fall_o = ~sck_q[STAGES-1] & sck_last_q;
  assign sdi_o  = sdi_q[STAGES-1];
endmodule

// File: rtl/sslv_tx_path.sv
module sslv_tx_path
  import sslv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbuf_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_start,
  input  logic          bit_shift,
  input  logic          frame_done,
  input  logic          idle,
  output logic          ser_o,
  output logic          udr_set,
  output logic          irq_o
);
  localparam logic [DW-1:0] FILL = '1;

  logic [DW-1:0] hold_q, hold_d, stage_q, stage_d, sh_q, sh_d;
  logic          hold_full_q, hold_full_d, stage_full_q, stage_full_d;
  logic          irq_q;
  txsrc_e        src;

  always_comb begin
    if (dbuf_en) src = stage_full_q ? TXSRC_STAGE : TXSRC_FILL;
    else         src = hold_full_q  ? TXSRC_HOLD  : TXSRC_FILL;
  end

  always_comb begin
    hold_d       = hold_q;
    hold_full_d  = hold_full_q;
    stage_d      = stage_q;
    stage_full_d = stage_full_q;
    sh_d         = sh_q;
    udr_set      = 1'b0;
    if (frame_start) begin
      unique case (src)
        TXSRC_STAGE: begin sh_d = stage_q; stage_full_d = 1'b0; end
        TXSRC_HOLD:  begin sh_d = hold_q;  hold_full_d  = 1'b0; end
        default:     begin sh_d = FILL;    udr_set      = dbuf_en; end
      endcase
    end else if (bit_shift) begin
      sh_d = {1'b1, sh_q[DW-1:1]};
    end
    // holding -> staging transfer at frame end, or while idle between frames
    if (dbuf_en && hold_full_q && !stage_full_d &&
        (frame_done || (idle && !frame_start))) begin
      stage_d      = hold_q;
      stage_full_d = 1'b1;
      hold_full_d  = 1'b0;
    end
    if (wr_en) begin
      hold_d      = wr_data;
      hold_full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q       <= '0;
      hold_full_q  <= 1'b0;
      stage_q      <= '0;
      stage_full_q <= 1'b0;
      sh_q         <= FILL;
      irq_q        <= 1'b0;
    end else begin
      hold_q       <= hold_d;
      hold_full_q  <= hold_full_d;
      stage_q      <= stage_d;
      stage_full_q <= stage_full_d;
      if (frame_start || bit_shift) sh_q <= sh_d;
      irq_q        <= frame_done;
    end
  end

  assign ser_o = sh_q[0];
  assign irq_o = irq_q;
endmodule

// File: rtl/sslv_rx_path.sv
module sslv_rx_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_rise,
  input  logic          frame_done,
  input  logic          sdi,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ovr_set,
  output logic          irq_o
);
  logic [DW-1:0] sh_q, sh_d, buf_q, buf_d;
  logic          valid_q, valid_d, irq_d, irq_q;

  always_comb begin
    sh_d    = sh_q;
    buf_d   = buf_q;
    valid_d = valid_q & ~rd_en;
    irq_d   = 1'b0;
    ovr_set = 1'b0;
    if (bit_rise) sh_d = {sdi, sh_q[DW-1:1]};
    if (frame_done) begin
      if (valid_d) begin
        ovr_set = 1'b1;
      end else begin
        buf_d   = {sdi, sh_q[DW-1:1]};
        valid_d = 1'b1;
        irq_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      buf_q   <= '0;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (bit_rise) sh_q <= sh_d;
      buf_q   <= buf_d;
      valid_q <= valid_d;
      irq_q   <= irq_d;
    end
  end

  assign rd_data  = buf_q;
  assign rd_valid = valid_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/sclk_slave_port.sv
module sclk_slave_port #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_sck,
  input  logic          ser_in,
  output logic          ser_out,
  input  logic          dbuf_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          err_clr,
  output logic          ovr_flag,
  output logic          udr_flag,
  output logic          tx_irq,
  output logic          rx_irq
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [1:0]    rst_sq;
  logic          rst_i_n;
  logic          rise, fall, sdi;
  logic          inframe_q, inframe_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          frame_start, bit_shift, bit_rise, frame_done;
  logic          ovr_set, udr_set;
  logic          ovr_q, ovr_d, udr_q, udr_d;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i_n = rst_sq[1];

  sslv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .sck_i(ext_sck), .sdi_i(ser_in),
    .rise_o(rise), .fall_o(fall), .sdi_o(sdi)
  );

  assign frame_start = fall & ~inframe_q;
  assign bit_shift   = fall &  inframe_q;
  assign bit_rise    = rise &  inframe_q;
  assign frame_done  = bit_rise & (cnt_q == LAST_BIT);

  always_comb begin
    inframe_d = inframe_q;
    cnt_d     = cnt_q;
    if (frame_start) begin
      inframe_d = 1'b1;
      cnt_d     = '0;
    end else if (bit_rise) begin
      if (frame_done) begin
        inframe_d = 1'b0;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    ovr_d = (ovr_q & ~err_clr) | ovr_set;
    udr_d = (udr_q & ~err_clr) | udr_set;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      inframe_q <= 1'b0;
      cnt_q     <= '0;
      ovr_q     <= 1'b0;
      udr_q     <= 1'b0;
    end else begin
      if (frame_start || bit_rise) begin
        inframe_q <= inframe_d;
        cnt_q     <= cnt_d;
      end
      ovr_q <= ovr_d;
      udr_q <= udr_d;
    end
  end

  sslv_tx_path #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .dbuf_en(dbuf_en), .wr_en(wr_en),
    .wr_data(wr_data), .frame_start(frame_start), .bit_shift(bit_shift),
    .frame_done(frame_done), .idle(~inframe_q), .ser_o(ser_out),
    .udr_set(udr_set), .irq_o(tx_irq)
  );

  sslv_rx_path #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .bit_rise(bit_rise), .frame_done(frame_done),
    .sdi(sdi), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .ovr_set(ovr_set), .irq_o(rx_irq)
  );

  assign ovr_flag = ovr_q;
  assign udr_flag = udr_q;
endmodule

// File: rtl/sslv_checker.sv
module sslv_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbuf_en,
  input logic          err_clr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          ovr_flag,
  input logic          udr_flag,
  input logic          tx_irq,
  input logic          rx_irq
);
  p_rx_loads_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rd_valid);

  p_rx_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  p_irq_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> tx_irq);

  p_udr_needs_dbuf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_flag) |-> $past(dbuf_en));

  p_ovr_keeps_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> (rd_valid && $stable(rd_data)));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !err_clr) |=> ovr_flag);

  p_udr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && !err_clr) |=> udr_flag);
endmodule

bind sclk_slave_port sslv_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbuf_en(dbuf_en), .err_clr(err_clr),
  .rd_data(rd_data), .rd_valid(rd_valid), .ovr_flag(ovr_flag),
  .udr_flag(udr_flag), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/sclk_slave_port_test.sv
`timescale 1ns/1ps
module sclk_slave_port_test;
  logic       clk = 1'b0;
  logic       rst_n, ext_sck, ser_in, dbuf_en, wr_en, rd_en, err_clr;
  logic [7:0] wr_data, rd_data;
  logic       ser_out, rd_valid, ovr_flag, udr_flag, tx_irq, rx_irq;

  int n_chk = 0, n_bad = 0, n_txirq = 0, n_rxirq = 0;

  // bench model state
  logic [7:0] m_hold, m_stage, m_rd;
  logic       m_hold_full, m_stage_full, m_rd_valid, m_ovr, m_udr;

  always #2 clk = ~clk;  // 250 MHz

  sclk_slave_port uut (
    .clk(clk), .rst_n(rst_n), .ext_sck(ext_sck), .ser_in(ser_in),
    .ser_out(ser_out), .dbuf_en(dbuf_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .err_clr(err_clr),
    .ovr_flag(ovr_flag), .udr_flag(udr_flag), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    if (tx_irq === 1'b1) n_txirq++;
    if (rx_irq === 1'b1) n_rxirq++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_tx();
    if (dbuf_en) return m_stage_full ? m_stage : 8'hFF;
    return m_hold_full ? m_hold : 8'hFF;
  endfunction

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; ext_sck = 1'b1; ser_in = 1'b0; dbuf_en = mode;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; err_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_hold_full = 0; m_stage_full = 0; m_rd_valid = 0; m_ovr = 0; m_udr = 0;
    m_hold = '0; m_stage = '0; m_rd = '0;
  endtask

  task automatic host_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    if (dbuf_en && !m_stage_full) begin m_stage = d; m_stage_full = 1; end
    else begin m_hold = d; m_hold_full = 1; end
  endtask

  task automatic host_read();
    chk("R3", {31'd0, rd_valid}, 1);
    chk("R3", {24'd0, rd_data}, {24'd0, m_rd});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    m_rd_valid = 0;
    @(negedge clk);
    chk("R10 read clears", {31'd0, rd_valid}, 0);
  endtask

  task automatic host_clear();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    m_ovr = 0; m_udr = 0;
    @(negedge clk);
    chk("R10 clear ovr", {31'd0, ovr_flag}, 0);
    chk("R10 clear udr", {31'd0, udr_flag}, 0);
  endtask

  task automatic run_frame(input logic [7:0] rxb);
    logic [7:0] seen, exp_tx;
    logic       exp_rxirq;
    int         tx0, rx0;
    exp_tx = pick_tx();
    if (dbuf_en) begin
      if (!m_stage_full) m_udr = 1;
      m_stage_full = 0;
    end else begin
      m_hold_full = 0;
    end
    tx0 = n_txirq; rx0 = n_rxirq;
    for (int b = 0; b < 8; b++) begin
      ext_sck = 1'b0; ser_in = rxb[b];
      repeat (8) @(negedge clk);
      seen[b] = ser_out;
      ext_sck = 1'b1;
      if (b < 7) repeat (8) @(negedge clk);
    end
    // frame end in the model
    if (dbuf_en && m_hold_full) begin
      m_stage = m_hold; m_stage_full = 1; m_hold_full = 0;
    end
    if (m_rd_valid) begin m_ovr = 1; exp_rxirq = 0; end
    else begin m_rd = rxb; m_rd_valid = 1; exp_rxirq = 1; end
    repeat (2) @(negedge clk);
    chk("R11 rx early", {31'd0, rx_irq}, 0);
    chk("R11 tx early", {31'd0, tx_irq}, 0);
    @(negedge clk);
    chk("R11 rx due", {31'd0, rx_irq}, {31'd0, exp_rxirq});
    chk("R5 tx due", {31'd0, tx_irq}, 1);
    repeat (5) @(negedge clk);
    chk(dbuf_en ? "R2 R7 tx byte" : "R2 R6 tx byte", {24'd0, seen}, {24'd0, exp_tx});
    chk("R4 rx pulses", n_rxirq - rx0, {31'd0, exp_rxirq});
    chk("R5 tx pulses", n_txirq - tx0, 1);
    chk("R4 rd_valid", {31'd0, rd_valid}, {31'd0, m_rd_valid});
    chk("R3 R9 rd_data", {24'd0, rd_data}, {24'd0, m_rd});
    chk("R9 ovr", {31'd0, ovr_flag}, {31'd0, m_ovr});
    chk("R8 udr", {31'd0, udr_flag}, {31'd0, m_udr});
  endtask

  task automatic random_frames(input int n);
    for (int f = 0; f < n; f++) begin
      int nw;
      nw = $urandom_range(0, 2);
      for (int i = 0; i < nw; i++) host_write(8'($urandom));
      if (m_rd_valid && $urandom_range(0, 3) != 0) host_read();
      if ($urandom_range(0, 4) == 0) host_clear();
      run_frame(8'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset(1'b0);
    // R1 reset state
    chk("R1 ser_out", {31'd0, ser_out}, 1);
    chk("R1 rd_valid", {31'd0, rd_valid}, 0);
    chk("R1 ovr", {31'd0, ovr_flag}, 0);
    chk("R1 udr", {31'd0, udr_flag}, 0);
    chk("R1 irqs", {30'd0, tx_irq, rx_irq}, 0);

    // single mode: written byte sent, then empty frame sends ones (R6), overrun (R9)
    host_write(8'hA5);
    run_frame(8'h3C);
    run_frame(8'hC3);
    repeat (20) @(negedge clk);
    chk("R10 ovr sticky", {31'd0, ovr_flag}, 1);
    chk("R6 no udr in single", {31'd0, udr_flag}, 0);
    host_read();
    host_clear();

    // double mode: two queued bytes in order (R7), then underrun (R8)
    do_reset(1'b1);
    host_write(8'h11);
    host_write(8'h22);
    run_frame(8'h01);
    host_read();
    run_frame(8'h80);
    host_read();
    run_frame(8'hFE);
    repeat (20) @(negedge clk);
    chk("R10 udr sticky", {31'd0, udr_flag}, 1);
    host_read();
    host_clear();

    random_frames(25);
    do_reset(1'b0);
    random_frames(25);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule